// File: doc/BRIEF.md
# Four-Lane Halfband Decimate-by-Two

This block halves the sample rate of a real signal that arrives four samples per clock. In each clock where `valid_i` is high, the four input lanes carry four consecutive full-rate samples. Lane k carries sample 4m+k of clock m. The block sends out two decimated samples per valid clock. The even lane carries the filtered full-rate output at index 4m. The odd lane carries the output at index 4m+2. The rate is halved without a full-rate clock. For example, 1400 MS/s in becomes 700 MS/s out on a 350 MHz clock.

The filter is a symmetric 40-tap halfband prototype with coefficients fixed at elaboration. It is split column-wise into four 10-tap branches. Branch p takes taps 4j+p. In a halfband prototype, branch 1 holds only zeros, so it is not built. Branch 3 holds only the centre tap, so it becomes a six-register delay line followed by one multiplier. Branches 0 and 2 are each built twice, once per output phase, and all four run together. The even output's branch-2 term uses lane 2 from the previous clock. That is done by keeping one more word of lane-2 history.

All sums are formed at full precision. The result is then rounded and saturated to the output width.

Top module: `hb_dec2_x4`

## Requirements
- R1: With x[4m+k] taken from lane k in the m-th valid clock, and y[n] = sum over t of h[t]*x[n-t] (t = 0..39, zero history before reset), `even_o` carries y[4m] and `odd_o` carries y[4m+2]. Both are bit-exact after the scaling of R4 and R5.
- R2: `valid_o` is high exactly two clocks after each clock with `valid_i` high, and low otherwise. The data for input clock m appears with that pulse.
- R3: A clock with `valid_i` low leaves the filter history unchanged, and its lane values are ignored. The output stream equals that of the same valid samples sent with no gaps.
- R4: Coefficients are Q1.17. The full-precision sum acc is scaled to floor((acc + 2^16) / 2^17), which rounds halves toward plus infinity.
- R5: A scaled value above 32767 gives 32767, and one below -32768 gives -32768.
- R6: While `rst_ni` is low, `valid_o`, `even_o` and `odd_o` are zero and all history is cleared. After release, the block behaves as if every earlier sample were zero.
- R7: A lane-1 sample from valid clock m reaches `even_o` for clock m+5, scaled by the centre tap h[19]. A lane-3 sample reaches `odd_o` for clock m+5 in the same way.
- R8: A lane-2 sample from clock m reaches `odd_o` for clock m through tap h[0]. It reaches `even_o` only from clock m+1 on, starting with tap h[2].
- R9: `even_o` and `odd_o` hold their value in every clock where `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input lanes carry four new samples |
| lane0_i | input | 16 | Full-rate sample 4m, signed |
| lane1_i | input | 16 | Full-rate sample 4m+1, signed |
| lane2_i | input | 16 | Full-rate sample 4m+2, signed |
| lane3_i | input | 16 | Full-rate sample 4m+3, signed |
| valid_o | output | 1 | Output lanes carry two new samples |
| even_o | output | 16 | Decimated sample at full-rate index 4m, signed |
| odd_o | output | 16 | Decimated sample at full-rate index 4m+2, signed |

## Verification
Two things can land on the same output word. One is the cross-clock lane-2 term of the even phase. The other is an idle gap in `valid_i` just before that clock. If history advanced during the gap, the previous-clock word would be wrong. Random traffic with random idle clocks, and garbage on the lanes while idle, provokes this case. A full-rate 40-tap direct-form model built only from the valid samples judges it. A second pairing is saturation on the same clock as the half-up rounding. Sign-matched full-scale patterns drive both output phases to the clamp, and the same model checks the clamped values bit for bit.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int unsigned LANES      = 4;
  localparam int unsigned COEF_W     = 18;
  localparam int unsigned PROTO_TAPS = 40;

  typedef logic signed [COEF_W-1:0] coef_t;

  // Q1.17 halfband prototype, symmetric about tap 19, last tap padded with zero
  localparam coef_t DEF_TAPS [PROTO_TAPS] = '{
    -18'sd190,   18'sd0,  18'sd420,    18'sd0, -18'sd780,   18'sd0,  18'sd1300,  18'sd0,
    -18'sd2050,  18'sd0,  18'sd3100,   18'sd0, -18'sd4700,  18'sd0,  18'sd7400,  18'sd0,
    -18'sd13200, 18'sd0,  18'sd41000,  18'sd65536, 18'sd41000, 18'sd0, -18'sd13200, 18'sd0,
     18'sd7400,  18'sd0, -18'sd4700,   18'sd0,  18'sd3100,  18'sd0, -18'sd2050,  18'sd0,
     18'sd1300,  18'sd0, -18'sd780,    18'sd0,  18'sd420,   18'sd0, -18'sd190,   18'sd0
  };
endpackage

// File: rtl/hb_hist.sv
module hb_hist #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [W-1:0]              d_i,
  output logic [DEPTH-1:0][W-1:0]   hist_o
);
  // hist_o[0] is the newest word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hist_o <= '0;
    else if (en_i) hist_o <= {hist_o[DEPTH-2:0], d_i};
  end

  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(hist_o)); // R3
endmodule

// File: rtl/hb_delay.sv
module hb_delay #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [DEPTH-1:0][W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   line_q <= '0;
    else if (en_i) line_q <= {line_q[DEPTH-2:0], d_i};
  end

  assign q_o = line_q[DEPTH-1];

  AST_DELAY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o)); // R3
endmodule

// File: rtl/hb_subfir.sv
module hb_subfir #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 39,
  parameter int unsigned NSUB  = 10,
  parameter int unsigned PHASE = 0,
  parameter hb_pkg::coef_t TAPS [hb_pkg::PROTO_TAPS] = hb_pkg::DEF_TAPS
) (
  input  logic [NSUB-1:0][IN_W-1:0] win_i,
  output logic signed [ACC_W-1:0]   acc_o
);
  always_comb begin
    acc_o = '0;
    for (int j = 0; j < NSUB; j++) begin
      acc_o = acc_o + ACC_W'($signed(win_i[j])) * ACC_W'(TAPS[hb_pkg::LANES*j+PHASE]);
    end
  end
endmodule

// File: rtl/hb_round_sat.sv
module hb_round_sat #(
  parameter int unsigned ACC_W = 39,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned FRAC  = 17
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [OUT_W-1:0] out_o
);
  localparam int unsigned RW = ACC_W + 1;
  localparam logic signed [RW-1:0] HALF = RW'(1) << (FRAC-1);
  localparam logic signed [RW-1:0] MAXV = RW'(2**(OUT_W-1) - 1);
  localparam logic signed [RW-1:0] MINV = -MAXV - RW'(1);

  logic signed [RW-1:0] sum, shr;

  always_comb begin
    sum = $signed({acc_i[ACC_W-1], acc_i}) + HALF;
    shr = sum >>> FRAC;
    if (shr > MAXV)      out_o = MAXV[OUT_W-1:0];
    else if (shr < MINV) out_o = MINV[OUT_W-1:0];
    else                 out_o = shr[OUT_W-1:0];
  end

  always_comb begin
    if (!$isunknown(acc_i) && !$isunknown(out_o)) begin
      if (acc_i >= 0) AST_SIGN_POS: assert (!out_o[OUT_W-1]); // R5
      if (acc_i < 0)  AST_SIGN_NEG: assert (out_o <= 0);      // R4
    end
  end
endmodule

// File: rtl/hb_dec2_x4.sv
module hb_dec2_x4 #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned FRAC  = hb_pkg::COEF_W - 1,
  parameter hb_pkg::coef_t TAPS [hb_pkg::PROTO_TAPS] = hb_pkg::DEF_TAPS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [IN_W-1:0]  lane0_i,
  input  logic signed [IN_W-1:0]  lane1_i,
  input  logic signed [IN_W-1:0]  lane2_i,
  input  logic signed [IN_W-1:0]  lane3_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] even_o,
  output logic signed [OUT_W-1:0] odd_o
);
  import hb_pkg::*;

  localparam int unsigned NTAPS = PROTO_TAPS;
  localparam int unsigned NSUB  = NTAPS / LANES;
  localparam int unsigned CTR   = NTAPS / 2 - 1;       // centre tap, phase 3
  localparam int unsigned CDLY  = CTR / LANES + 2;     // registers to reach clock m-(CTR/4+1)
  localparam int unsigned ACC_W = IN_W + COEF_W + $clog2(2*NSUB + 1);

  logic [NSUB-1:0][IN_W-1:0] h0;
  logic [NSUB:0][IN_W-1:0]   h2;      // one extra word: even phase reads previous clock
  logic [IN_W-1:0]           d1, d3;

  hb_hist  #(.W(IN_W), .DEPTH(NSUB))   u_h0 (.clk_i, .rst_ni, .en_i(valid_i), .d_i(lane0_i), .hist_o(h0));
  hb_hist  #(.W(IN_W), .DEPTH(NSUB+1)) u_h2 (.clk_i, .rst_ni, .en_i(valid_i), .d_i(lane2_i), .hist_o(h2));
  hb_delay #(.W(IN_W), .DEPTH(CDLY))   u_d1 (.clk_i, .rst_ni, .en_i(valid_i), .d_i(lane1_i), .q_o(d1));
  hb_delay #(.W(IN_W), .DEPTH(CDLY))   u_d3 (.clk_i, .rst_ni, .en_i(valid_i), .d_i(lane3_i), .q_o(d3));

  logic signed [ACC_W-1:0] e_p0, e_p2, o_p0, o_p2, e_ctr, o_ctr, e_acc, o_acc;

  hb_subfir #(.IN_W(IN_W), .ACC_W(ACC_W), .NSUB(NSUB), .PHASE(0), .TAPS(TAPS))
    u_e0 (.win_i(h0),           .acc_o(e_p0));
  hb_subfir #(.IN_W(IN_W), .ACC_W(ACC_W), .NSUB(NSUB), .PHASE(2), .TAPS(TAPS))
    u_e2 (.win_i(h2[NSUB:1]),   .acc_o(e_p2));
  hb_subfir #(.IN_W(IN_W), .ACC_W(ACC_W), .NSUB(NSUB), .PHASE(0), .TAPS(TAPS))
    u_o0 (.win_i(h2[NSUB-1:0]), .acc_o(o_p0));
  hb_subfir #(.IN_W(IN_W), .ACC_W(ACC_W), .NSUB(NSUB), .PHASE(2), .TAPS(TAPS))
    u_o2 (.win_i(h0),           .acc_o(o_p2));

  assign e_ctr = ACC_W'($signed(d1)) * ACC_W'(TAPS[CTR]);
  assign o_ctr = ACC_W'($signed(d3)) * ACC_W'(TAPS[CTR]);
  assign e_acc = e_p0 + e_p2 + e_ctr;
  assign o_acc = o_p0 + o_p2 + o_ctr;

  logic signed [OUT_W-1:0] e_rs, o_rs;

  hb_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_rs_e (.acc_i(e_acc), .out_o(e_rs));
  hb_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_rs_o (.acc_i(o_acc), .out_o(o_rs));

  logic v1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q    <= 1'b0;
      valid_o <= 1'b0;
      even_o  <= '0;
      odd_o   <= '0;
    end else begin
      v1_q    <= valid_i;
      valid_o <= v1_q;
      if (v1_q) begin
        even_o <= e_rs;
        odd_o  <= o_rs;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o); // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(even_o) && $stable(odd_o))); // R9
endmodule

// File: tb/test_hb_dec2_x4.sv
module test_hb_dec2_x4;
  import hb_pkg::*;

  localparam int FRAC = COEF_W - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] l0 = '0, l1 = '0, l2 = '0, l3 = '0;
  logic valid_o;
  logic signed [15:0] even_o, odd_o;

  hb_dec2_x4 i_hb_dec2_x4 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .lane0_i(l0), .lane1_i(l1), .lane2_i(l2), .lane3_i(l3),
    .valid_o(valid_o), .even_o(even_o), .odd_o(odd_o)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  string req = "R1";
  longint xs[$];
  longint exp_e[$], exp_o[$];
  int exp_c[$];

  function automatic longint ref_y(int n);
    longint acc = 0, r;
    for (int t = 0; t < PROTO_TAPS; t++)
      if (n - t >= 0) acc += longint'(DEF_TAPS[t]) * xs[n-t];
    r = (acc + (longint'(1) <<< (FRAC-1))) >>> FRAC;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(string r, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic step(bit v, longint a0, longint a1, longint a2, longint a3);
    int m;
    @(negedge clk);
    cyc++;
    if (valid_o) begin
      if (exp_e.size() == 0) check("R2 spurious valid_o", 1, 0);
      else begin
        check({req, " even"}, even_o, exp_e.pop_front());
        check({req, " odd"},  odd_o,  exp_o.pop_front());
        check("R2 latency", cyc - exp_c.pop_front(), 2);
      end
    end else if (exp_c.size() > 0 && cyc - exp_c[0] >= 2) begin
      check("R2 missing valid_o", 0, 1);
      void'(exp_c.pop_front()); void'(exp_e.pop_front()); void'(exp_o.pop_front());
    end
    valid_i = v;
    l0 = 16'(a0); l1 = 16'(a1); l2 = 16'(a2); l3 = 16'(a3);
    if (v) begin
      xs.push_back(a0); xs.push_back(a1); xs.push_back(a2); xs.push_back(a3);
      m = xs.size() / 4 - 1;
      exp_e.push_back(ref_y(4*m));
      exp_o.push_back(ref_y(4*m + 2));
      exp_c.push_back(cyc);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; valid_i = 1'b0;
    xs.delete(); exp_e.delete(); exp_o.delete(); exp_c.delete();
    @(negedge clk);
    check("R6 valid_o in reset", valid_o, 0);
    check("R6 even_o in reset", even_o, 0);
    check("R6 odd_o in reset", odd_o, 0);
    rst_ni = 1'b1;
  endtask

  function automatic longint rnd16();
    return longint'($signed(16'($urandom)));
  endfunction

  task automatic sat_pattern(bit neg);
    longint p[48];
    for (int n = 0; n < 48; n++) begin
      int t = 44 - n;
      p[n] = 0;
      if (t >= 0 && t < PROTO_TAPS) begin
        if (DEF_TAPS[t] > 0) p[n] = neg ? -32768 : 32767;
        if (DEF_TAPS[t] < 0) p[n] = neg ? 32767 : -32768;
      end
    end
    for (int c = 0; c < 12; c++) step(1, p[4*c], p[4*c+1], p[4*c+2], p[4*c+3]);
    for (int c = 0; c < 4; c++) step(1, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R6: reset state
    repeat (2) @(negedge clk);
    check("R6 valid_o at reset", valid_o, 0);
    check("R6 even_o at reset", even_o, 0);
    check("R6 odd_o at reset", odd_o, 0);
    rst_ni = 1'b1;

    // R7: centre-tap paths
    req = "R7";
    step(1, 0, 1000, 0, 0);
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, -3000);
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0);
    idle(3);

    // R8: lane 2 reaches odd at once, even one clock later
    req = "R8";
    step(1, 0, 0, 4000, 0);
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0);
    idle(3);

    // R4: exact halves round up
    do_reset();
    req = "R4";
    step(1, 0, 1001, 0, -1001);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0);
    step(1, 0, -1001, 0, 1);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0);
    idle(3);

    // R1: continuous random
    req = "R1";
    for (int i = 0; i < 400; i++) step(1, rnd16(), rnd16(), rnd16(), rnd16());
    idle(3);

    // R3: random gaps with garbage on idle lanes
    req = "R3";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(9) < 6) step(1, rnd16(), rnd16(), rnd16(), rnd16());
      else step(0, rnd16(), rnd16(), rnd16(), rnd16());
    end
    idle(3);

    // R5: sign-matched full-scale patterns
    do_reset();
    req = "R5";
    sat_pattern(1'b0);
    idle(3);
    do_reset();
    sat_pattern(1'b1);
    idle(3);

    // R6: mid-run reset clears history
    req = "R6";
    for (int i = 0; i < 20; i++) step(1, rnd16(), rnd16(), rnd16(), rnd16());
    idle(3);
    do_reset();
    step(1, 2000, 0, 0, 0);
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0);
    idle(3);

    // R9: outputs hold while valid_o low
    begin
      logic signed [15:0] e_s, o_s;
      @(negedge clk);
      e_s = even_o; o_s = odd_o;
      idle(4);
      check("R9 even hold", even_o, e_s);
      check("R9 odd hold", odd_o, o_s);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule